// File: doc/BRIEF.md
# Host Bus Width Bridge

This block joins an external host bus to an internal register and data port that is always one DWORD (two halfwords) wide. A strap input picks the host width. It is captured on the first clock edge after reset is released and then held. With a full-width host, every access goes straight through to the internal port. With a half-width host, the block pairs two halfword writes into one internal DWORD write. It also answers two halfword reads from a single internal DWORD read, so a register whose read has side effects is read only once per DWORD.

In half-width mode, host address bit 1 picks the half: 0 is the lower halfword and 1 is the upper halfword. The address bits from 2 upward name the DWORD that the two halves belong to, and the halves may come in either order. Reads of one configurable DWORD have one bit, position 2 by default, replaced with the captured width, so software can find out how the bus was strapped.

The host handshake is simple and synchronous. A write strobe or a read strobe is valid for one cycle. Read data returns, flagged valid, on the following cycle. The internal port returns read data one cycle after its read strobe.

Top module: `hwb_bridge`

## Requirements
- R1: The width strap is captured on the first clock edge after reset release (1 = half-width, 0 = full-width). Later changes of the strap have no effect on how accesses are handled until the next reset.
- R2: A host read of DWORD index CFG_DWORD (byte address 0x60 by default) returns the internal word with bit CFG_BIT (bit 2) replaced by the captured width: 1 in half-width mode, 0 in full-width mode.
- R3: In full-width mode, a host write drives an internal write in the same cycle, with the same data and DWORD address. A host read drives an internal read in the same cycle, and the full internal word is returned on the next cycle.
- R4: In half-width mode, an internal write is issued only in the cycle when the second half of one DWORD arrives, with either order allowed. The internal data is {upper half, lower half}, taken from host_wdata[15:0] of the respective writes. Reads in between do not disturb the pairing.
- R5: In half-width mode, writing the same half of the same DWORD again before its partner arrives replaces the stored half and issues no internal write.
- R6: In half-width mode, a write to a different DWORD while one half is pending drops that pending half and starts a new pairing from the new write.
- R7: In half-width mode, a read that the latch cannot serve issues exactly one internal read and latches the whole DWORD. The selected half is returned in host_rdata[15:0] with host_rdata[31:16] zero.
- R8: In half-width mode, the next read of the same DWORD after a fetch is served from the latch with no internal read, even when it follows the fetch directly. Serving it releases the latch, so a further read fetches again.
- R9: In half-width mode, any host write releases the read latch.
- R10: host_rvalid is high in exactly the cycles that follow a cycle with host_rd high and host_wr low. Outside valid cycles, host_rdata is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| strap_half_bus | input | 1 | Width strap, 1 selects half-width host |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_addr | input | AW-1 | Host byte address bits AW-1 down to 1 |
| host_wdata | input | 32 | Host write data; lower 16 bits used in half-width mode |
| host_rvalid | output | 1 | Host read data valid |
| host_rdata | output | 32 | Host read data |
| int_wr | output | 1 | Internal write strobe |
| int_rd | output | 1 | Internal read strobe |
| int_addr | output | AW-2 | Internal DWORD index |
| int_wdata | output | 32 | Internal write data |
| int_rdata | input | 32 | Internal read data, valid the cycle after int_rd |

## Verification
The half-width writes are driven in several patterns: lower half first, upper half first, a repeated half, and a DWORD change while a half is pending. Between them, these separate true pairing from replacement and from discard. The half-width reads are driven as a fetch followed directly by its partner, as the same half twice, and as a partner read after an intervening write. This shows whether the latch forwards, releases and is cleared at the right moments. Full-width accesses and the configuration DWORD are read in both modes, and the strap is toggled after reset, to confirm that the width is frozen and reported correctly.

// File: rtl/hwb_pkg.sv
package hwb_pkg;

   typedef enum logic {
      HWB_BUS_FULL = 1'b0,
      HWB_BUS_HALF = 1'b1
   } hwb_width_e;

   // Tag carried from a host read to the cycle its data is returned
   typedef struct packed {
      logic valid;
      logic from_latch;
      logic hi_half;
      logic is_cfg;
      logic narrow;
   } hwb_rsp_t;

endpackage

// File: rtl/hwb_mode_latch.sv
module hwb_mode_latch
   import hwb_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       strap,
   output hwb_width_e mode,
   output logic       armed
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode  <= HWB_BUS_FULL;
         armed <= 1'b0;
      end else if (!armed) begin
         mode  <= strap ? HWB_BUS_HALF : HWB_BUS_FULL;
         armed <= 1'b1;
      end
   end

endmodule

// File: rtl/hwb_wr_join.sv
module hwb_wr_join #(
   parameter int DW_W   = 6,
   parameter int HALF_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr,
   input  logic [DW_W-1:0]     dw,
   input  logic                hi_sel,
   input  logic [HALF_W-1:0]   half_data,
   output logic                fire,
   output logic [2*HALF_W-1:0] word
);

   logic              have_lo, have_hi;
   logic [DW_W-1:0]   dw_q;
   logic [HALF_W-1:0] lo_q, hi_q;
   logic              same_dw, partner_in;

   assign same_dw    = (have_lo | have_hi) && (dw == dw_q);
   assign partner_in = hi_sel ? have_lo : have_hi;
   assign fire       = wr && same_dw && partner_in;
   assign word       = hi_sel ? {half_data, lo_q} : {hi_q, half_data};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_lo <= 1'b0;
         have_hi <= 1'b0;
         dw_q    <= '0;
         lo_q    <= '0;
         hi_q    <= '0;
      end else if (wr) begin
         if (fire) begin
            have_lo <= 1'b0;
            have_hi <= 1'b0;
         end else begin
            if (!same_dw) begin
               dw_q    <= dw;
               have_lo <= !hi_sel;
               have_hi <= hi_sel;
            end else if (hi_sel) begin
               have_hi <= 1'b1;
            end else begin
               have_lo <= 1'b1;
            end
            if (hi_sel) hi_q <= half_data;
            else        lo_q <= half_data;
         end
      end
   end

endmodule

// File: rtl/hwb_rd_split.sv
module hwb_rd_split #(
   parameter int DW_W   = 6,
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd,
   input  logic              wr,
   input  logic [DW_W-1:0]   dw,
   input  logic              fill,
   input  logic [WORD_W-1:0] fill_word,
   output logic              hit,
   output logic              fetch,
   output logic [WORD_W-1:0] lat_word
);

   logic            lat_valid;
   logic [DW_W-1:0] lat_dw;

   // A fill arriving this cycle already counts as held data
   assign hit   = rd && (lat_valid || fill) && (dw == lat_dw);
   assign fetch = rd && !hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_valid <= 1'b0;
         lat_dw    <= '0;
         lat_word  <= '0;
      end else begin
         if (fill) lat_word <= fill_word;
         if (wr || hit) begin
            lat_valid <= 1'b0;
         end else if (fetch) begin
            lat_valid <= 1'b0;
            lat_dw    <= dw;
         end else if (fill) begin
            lat_valid <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/hwb_bridge.sv
module hwb_bridge
   import hwb_pkg::*;
#(
   parameter int AW        = 8,
   parameter int HALF_W    = 16,
   parameter int CFG_DWORD = 24,
   parameter int CFG_BIT   = 2,
   parameter bit NARROW_EN = 1'b1
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                strap_half_bus,
   input  logic                                host_wr,
   input  logic                                host_rd,
   input  logic [AW-1:$clog2(HALF_W/8)]        host_addr,
   input  logic [2*HALF_W-1:0]                 host_wdata,
   output logic                                host_rvalid,
   output logic [2*HALF_W-1:0]                 host_rdata,
   output logic                                int_wr,
   output logic                                int_rd,
   output logic [AW-1:$clog2(HALF_W/8)+1]      int_addr,
   output logic [2*HALF_W-1:0]                 int_wdata,
   input  logic [2*HALF_W-1:0]                 int_rdata
);

   localparam int HBIT      = $clog2(HALF_W/8);
   localparam int LANE_BITS = HBIT + 1;
   localparam int WORD_W    = 2 * HALF_W;
   localparam int DW_W      = AW - LANE_BITS;

   if (HALF_W < 8 || (HALF_W % 8) != 0 || (HALF_W & (HALF_W - 1)) != 0) begin : g_bad_half
      $error("HALF_W must be a power of two of at least 8");
   end
   if (AW <= LANE_BITS) begin : g_bad_aw
      $error("AW too small for a DWORD index");
   end
   if (CFG_BIT < 0 || CFG_BIT >= HALF_W) begin : g_bad_cfg_bit
      $error("CFG_BIT must lie in the lower half");
   end
   if (CFG_DWORD < 0 || CFG_DWORD >= (1 << DW_W)) begin : g_bad_cfg_dw
      $error("CFG_DWORD outside the address space");
   end

   hwb_width_e        bus_mode;
   logic              mode_armed, mode_narrow;
   logic [DW_W-1:0]   acc_dw;
   logic              acc_hi, rd_go;
   logic              join_fire, lat_hit, lat_fetch, fill;
   logic [WORD_W-1:0] join_word, lat_word, fetched_word, resp_word;
   hwb_rsp_t          rsp_q;

   hwb_mode_latch u_mode (
      .clk   (clk),
      .rst_n (rst_n),
      .strap (strap_half_bus),
      .mode  (bus_mode),
      .armed (mode_armed)
   );

   assign mode_narrow = NARROW_EN && mode_armed && (bus_mode == HWB_BUS_HALF);
   assign acc_dw      = host_addr[AW-1:LANE_BITS];
   assign acc_hi      = host_addr[HBIT];
   assign rd_go       = host_rd & ~host_wr;

   if (NARROW_EN) begin : g_narrow
      hwb_wr_join #(.DW_W(DW_W), .HALF_W(HALF_W)) u_join (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr        (host_wr & mode_narrow),
         .dw        (acc_dw),
         .hi_sel    (acc_hi),
         .half_data (host_wdata[HALF_W-1:0]),
         .fire      (join_fire),
         .word      (join_word)
      );
      hwb_rd_split #(.DW_W(DW_W), .WORD_W(WORD_W)) u_split (
         .clk       (clk),
         .rst_n     (rst_n),
         .rd        (rd_go & mode_narrow),
         .wr        (host_wr & mode_narrow),
         .dw        (acc_dw),
         .fill      (fill),
         .fill_word (fetched_word),
         .hit       (lat_hit),
         .fetch     (lat_fetch),
         .lat_word  (lat_word)
      );
   end else begin : g_full_only
      assign join_fire = 1'b0;
      assign join_word = '0;
      assign lat_hit   = 1'b0;
      assign lat_fetch = 1'b0;
      assign lat_word  = '0;
   end

   // Internal side
   assign int_wr    = mode_narrow ? join_fire : host_wr;
   assign int_wdata = mode_narrow ? join_word : host_wdata;
   assign int_rd    = mode_narrow ? lat_fetch : rd_go;
   assign int_addr  = acc_dw;

   // Response tag
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_q <= '0;
      end else begin
         rsp_q.valid      <= rd_go;
         rsp_q.from_latch <= mode_narrow & lat_hit;
         rsp_q.hi_half    <= acc_hi;
         rsp_q.is_cfg     <= (acc_dw == DW_W'(CFG_DWORD));
         rsp_q.narrow     <= mode_narrow;
      end
   end

   always_comb begin
      fetched_word = int_rdata;
      if (rsp_q.is_cfg) fetched_word[CFG_BIT] = rsp_q.narrow;
   end

   assign fill      = rsp_q.valid & rsp_q.narrow & ~rsp_q.from_latch;
   assign resp_word = rsp_q.from_latch ? lat_word : fetched_word;

   always_comb begin
      host_rdata = '0;
      if (rsp_q.valid) begin
         if (rsp_q.narrow)
            host_rdata[HALF_W-1:0] = rsp_q.hi_half ? resp_word[WORD_W-1:HALF_W]
                                                   : resp_word[HALF_W-1:0];
         else
            host_rdata = resp_word;
      end
   end
   assign host_rvalid = rsp_q.valid;

endmodule

// File: rtl/hwb_checker.sv
module hwb_checker #(
   parameter int AW   = 8,
   parameter int HBIT = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              armed,
   input logic              narrow,
   input logic              host_wr,
   input logic              host_rd,
   input logic [AW-1:HBIT]  host_addr,
   input logic              int_wr,
   input logic              int_rd,
   input logic              host_rvalid
);

   // R1: width frozen once captured
   a_r1_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      armed |=> $stable(narrow));

   // R3: full-width writes reach the internal port in the same cycle
   a_r3_full_write_passes: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !narrow) |-> (int_wr == host_wr));

   // R4: a joined write only happens while a host write is present
   a_r4_join_needs_host: assert property (@(posedge clk) disable iff (!rst_n)
      (narrow && int_wr) |-> host_wr);

   // R5: the same half written twice in a row never completes a DWORD
   a_r5_repeat_half_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (narrow && host_wr && $past(host_wr) && host_addr == $past(host_addr)) |-> !int_wr);

   // R8: internal reads are only ever caused by host reads
   a_r8_read_needs_host: assert property (@(posedge clk) disable iff (!rst_n)
      int_rd |-> host_rd);

   // R10: read data valid follows each read by one cycle
   a_r10_rvalid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && !host_wr) |=> host_rvalid);

   a_r10_rvalid_only: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_rd && !host_wr) |=> !host_rvalid);

endmodule

bind hwb_bridge hwb_checker #(.AW(AW), .HBIT(HBIT)) u_hwb_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .armed       (mode_armed),
   .narrow      (mode_narrow),
   .host_wr     (host_wr),
   .host_rd     (host_rd),
   .host_addr   (host_addr),
   .int_wr      (int_wr),
   .int_rd      (int_rd),
   .host_rvalid (host_rvalid)
);

// File: tb/hwb_bridge_tb_top.sv
module hwb_bridge_tb_top;

   typedef struct packed {
      logic [1:0]  op;    // 0 idle, 1 write, 2 read
      logic [7:0]  addr;  // byte address
      logic [15:0] wd;
      logic        xw;
      logic        xr;
      logic [31:0] xwd;
      logic [15:0] xrd;
      logic [3:0]  req;
   } vec_t;

   // Half-width walk; internal word at DWORD i starts as {16'hBE00|i, 16'h4200|i}
   localparam vec_t TBL [0:21] = '{
      '{2'd1, 8'h10, 16'h1111, 1'b0, 1'b0, 32'h0,         16'h0,    4'd4}, // R4 low first
      '{2'd1, 8'h12, 16'h2222, 1'b1, 1'b0, 32'h2222_1111, 16'h0,    4'd4},
      '{2'd1, 8'h26, 16'h3333, 1'b0, 1'b0, 32'h0,         16'h0,    4'd4}, // R4 high first
      '{2'd1, 8'h24, 16'h4444, 1'b1, 1'b0, 32'h3333_4444, 16'h0,    4'd4},
      '{2'd1, 8'h30, 16'h5555, 1'b0, 1'b0, 32'h0,         16'h0,    4'd5}, // R5 repeat
      '{2'd1, 8'h30, 16'h6666, 1'b0, 1'b0, 32'h0,         16'h0,    4'd5},
      '{2'd1, 8'h32, 16'h7777, 1'b1, 1'b0, 32'h7777_6666, 16'h0,    4'd5},
      '{2'd1, 8'h40, 16'h8888, 1'b0, 1'b0, 32'h0,         16'h0,    4'd6}, // R6 discard
      '{2'd1, 8'h46, 16'h9999, 1'b0, 1'b0, 32'h0,         16'h0,    4'd6},
      '{2'd1, 8'h42, 16'hAAAA, 1'b0, 1'b0, 32'h0,         16'h0,    4'd6},
      '{2'd1, 8'h40, 16'hBBBB, 1'b1, 1'b0, 32'hAAAA_BBBB, 16'h0,    4'd6},
      '{2'd2, 8'h10, 16'h0,    1'b0, 1'b1, 32'h0,         16'h1111, 4'd7}, // R7 fetch
      '{2'd2, 8'h12, 16'h0,    1'b0, 1'b0, 32'h0,         16'h2222, 4'd8}, // R8 forward
      '{2'd2, 8'h12, 16'h0,    1'b0, 1'b1, 32'h0,         16'h2222, 4'd8}, // R8 released
      '{2'd2, 8'h24, 16'h0,    1'b0, 1'b1, 32'h0,         16'h4444, 4'd7},
      '{2'd1, 8'h50, 16'hCCCC, 1'b0, 1'b0, 32'h0,         16'h0,    4'd9}, // R9 clear
      '{2'd2, 8'h26, 16'h0,    1'b0, 1'b1, 32'h0,         16'h3333, 4'd9},
      '{2'd2, 8'h60, 16'h0,    1'b0, 1'b1, 32'h0,         16'h421C, 4'd2}, // R2 bit set
      '{2'd2, 8'h62, 16'h0,    1'b0, 1'b0, 32'h0,         16'hBE18, 4'd8},
      '{2'd1, 8'h52, 16'hDDDD, 1'b1, 1'b0, 32'hDDDD_CCCC, 16'h0,    4'd4}, // R4 across reads
      '{2'd2, 8'h50, 16'h0,    1'b0, 1'b1, 32'h0,         16'hCCCC, 4'd7},
      '{2'd2, 8'h52, 16'h0,    1'b0, 1'b0, 32'h0,         16'hDDDD, 4'd8}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        strap = 1'b0;
   logic        host_wr = 1'b0, host_rd = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] host_wdata = '0;
   logic        host_rvalid;
   logic [31:0] host_rdata;
   logic        int_wr, int_rd;
   logic [5:0]  int_addr;
   logic [31:0] int_wdata;
   logic [31:0] int_rdata;
   logic [31:0] mem [0:63];
   int          checks = 0;
   int          fails = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   hwb_bridge dut_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .strap_half_bus (strap),
      .host_wr        (host_wr),
      .host_rd        (host_rd),
      .host_addr      (addr[7:1]),
      .host_wdata     (host_wdata),
      .host_rvalid    (host_rvalid),
      .host_rdata     (host_rdata),
      .int_wr         (int_wr),
      .int_rd         (int_rd),
      .int_addr       (int_addr),
      .int_wdata      (int_wdata),
      .int_rdata      (int_rdata)
   );

   // Internal register file model
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 64; i++) mem[i] <= {16'hBE00 | 16'(i), 16'h4200 | 16'(i)};
         int_rdata <= '0;
      end else begin
         if (int_wr) mem[int_addr] <= int_wdata;
         int_rdata <= int_rd ? mem[int_addr] : 32'h0;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic do_reset(input logic s);
      host_wr = 1'b0;
      host_rd = 1'b0;
      strap   = s;
      rst_n   = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   // Drive one access at a falling edge, settle combinational outputs
   task automatic step(input logic w, input logic r, input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      host_wr    = w;
      host_rd    = r;
      addr       = a;
      host_wdata = d;
      #1;
   endtask

   task automatic resp();
      @(posedge clk);
      #1;
   endtask

   initial begin
      // ---- full-width phase ----
      do_reset(1'b0);
      chk("R10 reset rvalid", 32'(host_rvalid), 32'h0);
      chk("R3 reset int_wr", 32'(int_wr), 32'h0);
      chk("R3 reset int_rd", 32'(int_rd), 32'h0);

      step(1'b1, 1'b0, 8'h14, 32'h1234_5678);
      chk("R3 write strobe", 32'(int_wr), 32'h1);
      chk("R3 write data", int_wdata, 32'h1234_5678);
      chk("R3 write addr", 32'(int_addr), 32'h5);
      resp();
      chk("R10 no rvalid after write", 32'(host_rvalid), 32'h0);

      step(1'b0, 1'b1, 8'h14, 32'h0);
      chk("R3 read strobe", 32'(int_rd), 32'h1);
      resp();
      chk("R10 rvalid", 32'(host_rvalid), 32'h1);
      chk("R3 read data", host_rdata, 32'h1234_5678);

      step(1'b1, 1'b0, 8'h60, 32'hFFFF_FFFF);
      resp();
      step(1'b0, 1'b1, 8'h60, 32'h0);
      resp();
      chk("R2 cfg bit clear in full mode", host_rdata, 32'hFFFF_FFFB);

      strap = 1'b1;
      step(1'b1, 1'b0, 8'h18, 32'hAABB_CCDD);
      chk("R1 strap change ignored", 32'(int_wr), 32'h1);
      resp();
      step(1'b0, 1'b0, 8'h0, 32'h0);
      resp();
      chk("R10 idle rvalid", 32'(host_rvalid), 32'h0);
      chk("R10 idle rdata", host_rdata, 32'h0);

      // ---- half-width phase: table walk ----
      do_reset(1'b1);
      for (int i = 0; i < 22; i++) begin
         step(TBL[i].op == 2'd1, TBL[i].op == 2'd2, TBL[i].addr, {16'hF00F, TBL[i].wd});
         chk($sformatf("R%0d vec %0d int_wr", TBL[i].req, i), 32'(int_wr), 32'(TBL[i].xw));
         chk($sformatf("R%0d vec %0d int_rd", TBL[i].req, i), 32'(int_rd), 32'(TBL[i].xr));
         if (TBL[i].xw) begin
            chk($sformatf("R%0d vec %0d int_wdata", TBL[i].req, i), int_wdata, TBL[i].xwd);
            chk($sformatf("R%0d vec %0d int_addr", TBL[i].req, i), 32'(int_addr), 32'(TBL[i].addr[7:2]));
         end
         if (TBL[i].xr)
            chk($sformatf("R%0d vec %0d int_addr", TBL[i].req, i), 32'(int_addr), 32'(TBL[i].addr[7:2]));
         resp();
         chk($sformatf("R10 vec %0d rvalid", i), 32'(host_rvalid), 32'(TBL[i].op == 2'd2));
         if (TBL[i].op == 2'd2)
            chk($sformatf("R%0d vec %0d rdata", TBL[i].req, i), host_rdata, {16'h0, TBL[i].xrd});
      end

      // ---- directed corner cases ----
      strap = 1'b0;
      step(1'b1, 1'b0, 8'h70, 32'h0000_1234);
      chk("R1 stays half-width", 32'(int_wr), 32'h0);
      resp();
      step(1'b0, 1'b1, 8'h60, 32'h0);
      resp();
      chk("R2 cfg bit set in half mode", host_rdata, 32'h0000_421C);
      step(1'b1, 1'b1, 8'h12, 32'h0);
      chk("R10 write wins over read", 32'(int_rd), 32'h0);
      resp();
      chk("R10 no rvalid with write", 32'(host_rvalid), 32'h0);
      step(1'b0, 1'b0, 8'h0, 32'h0);
      resp();

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

endmodule